// File: doc/BRIEF.md
# Parallel EEPROM Page Write Sequencer

This block sits on the host side of a byte-wide parallel EEPROM. A request carries a start address and a byte count from 1 to 256. The block then takes that many bytes from a valid/ready stream and performs one write cycle on the memory pins for each byte. Every byte goes into the page named by the start address. The low address byte counts up from the start offset and wraps inside the page. The block keeps the memory's byte-load window open: the interval between two write-enable falling edges stays bounded. If the stream stalls too long, the block closes the page early and raises a short-load flag.

Once the last byte is loaded, the block waits for the internal programming cycle to finish by reading the last written address again and again. An input chosen with the request selects one of two polling methods:

- Data polling compares the top data bit of each read with the top bit of the saved byte.
- Toggle polling compares bit 6 across two consecutive reads.

When programming completes, the block gives a one-cycle `done` pulse. If completion is never seen within a bounded number of reads, it gives a one-cycle `timeout_err` pulse instead.

Back-pressure rules:

- `req_ready` is high only while the block is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high.
- `s_ready` is high only while the block waits for the next byte. A byte is taken on a cycle where `s_valid` and `s_ready` are both high.
- The block ignores a valid that is offered while the matching ready is low. The source must hold the byte stable until it is accepted.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `req_ready` is 1, and `s_ready`, `done` and `timeout_err` are 0.
- R2: Byte j of a request with start address A is written to the address whose bits above PAGE_BITS equal those of A, and whose low PAGE_BITS equal (A + j) mod 2^PAGE_BITS. Bytes are written in stream order. Legal values of `req_len` are 1 to 256.
- R3: `mem_we_n` is low only while `mem_ce_n` is low and `mem_oe_n` is high. Each write-enable low pulse and its setup and hold phases last PHASE_CYC cycles each.
- R4: Exactly one byte is taken per stream handshake. A byte offered while `s_ready` is low is not written. After a full load, the number of written bytes equals `req_len`.
- R5: Within one request, two consecutive falling edges of `mem_we_n` are no more than GAP_LIMIT+PHASE_CYC+1 cycles apart.
- R6: Suppose at least one byte is loaded, and the block has waited GAP_LIMIT cycles since the last write-enable fall with no byte offered. The block then stops loading and polls on the last loaded byte. `short_load` reads 1 together with the outcome pulse. After a full load, `short_load` reads 0.
- R7: `mem_dq_oe` is 0 while `mem_oe_n` is low. It is also 0 in the cycle before each falling edge of `mem_oe_n`.
- R8: In data polling mode (`req_toggle_mode`=0), `done` follows the first read whose bit 7 equals bit 7 of the last written byte.
- R9: In toggle polling mode (`req_toggle_mode`=1), `done` follows the first read whose bit 6 equals bit 6 of the read just before it. The first read of a request never completes.
- R10: If POLL_READS_MAX reads pass without completion, `timeout_err` pulses instead of `done`. If the final allowed read completes, `done` wins. The two pulses never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Start address; upper bits select the page |
| req_len | input | PAGE_BITS+1 | Byte count, 1 to 2^PAGE_BITS |
| req_toggle_mode | input | 1 | 0: data polling, 1: toggle polling |
| s_valid | input | 1 | Stream byte offered |
| s_ready | output | 1 | Waiting for the next byte |
| s_data | input | DATA_W | Stream byte |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data driven to the memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | DATA_W | Data read from the memory |
| done | output | 1 | One-cycle pulse: programming complete |
| timeout_err | output | 1 | One-cycle pulse: polling limit reached |
| short_load | output | 1 | Page closed early by a stream stall |

## Verification
Two functions can fall on the same read: completion detection and expiry of the polling limit. The bench runs a memory model that stays busy for a chosen number of reads, and sweeps that number over both polling modes. In some runs the completing read is exactly the last allowed read; in those runs the bench expects `done` with no `timeout_err`. The bench computes the expected read count and outcome from the busy count and the last byte's bits 7 and 6. The byte-arrival and stall-abort paths are also driven against each other: one run stalls just inside the window and one stalls past it.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_PREL,
    ST_PREAD,
    ST_PEND
  } eepw_state_e;
endpackage

// File: rtl/eepw_phase_timer.sv
module eepw_phase_timer #(
  parameter int CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expired
);
  localparam int W = (CYC < 2) ? 1 : $clog2(CYC + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (restart) cnt_q <= W'(CYC - 1);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/eepw_gap_guard.sv
module eepw_gap_guard #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we_fall,
  output logic stale
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (we_fall) cnt_q <= '0;
    else if (cnt_q != W'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign stale = (cnt_q == W'(LIMIT));
endmodule

// File: rtl/eepw_poll_judge.sv
module eepw_poll_judge (
  input  logic toggle_mode,
  input  logic rd_b7,
  input  logic rd_b6,
  input  logic saved_b7,
  input  logic prev_b6,
  input  logic have_prev,
  output logic complete
);
  always_comb begin
    if (toggle_mode) complete = have_prev && (rd_b6 == prev_b6);
    else             complete = (rd_b7 == saved_b7);
  end
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eepw_pkg::*;
#(
  parameter int ADDR_W         = 17,
  parameter int DATA_W         = 8,
  parameter int PAGE_BITS      = 8,
  parameter int PHASE_CYC      = 4,
  parameter int GAP_LIMIT      = 10000,
  parameter int POLL_READS_MAX = 140000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [PAGE_BITS:0]   req_len,
  input  logic                 req_toggle_mode,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [DATA_W-1:0]    s_data,
  output logic                 mem_ce_n,
  output logic                 mem_oe_n,
  output logic                 mem_we_n,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_dq_out,
  output logic                 mem_dq_oe,
  input  logic [DATA_W-1:0]    mem_dq_in,
  output logic                 done,
  output logic                 timeout_err,
  output logic                 short_load
);
  localparam int LEN_W = PAGE_BITS + 1;
  localparam int RD_W  = $clog2(POLL_READS_MAX + 1);

  eepw_state_e state_q, state_d;
  logic [ADDR_W-1:0] base_q, addr_q;
  logic [LEN_W-1:0]  len_q, cnt_q;
  logic [DATA_W-1:0] data_q;
  logic [RD_W-1:0]   reads_q;
  logic mode_q, short_q, done_q, err_q;
  logic rd_b7_q, rd_b6_q, prev_b6_q, have_prev_q;
  logic phase_exp, stale, complete, we_fall, last_read;
  logic unused_rd_bits;

  assign unused_rd_bits = ^mem_dq_in[DATA_W-3:0];

  eepw_phase_timer #(.CYC(PHASE_CYC)) u_phase (
    .clk(clk), .rst_n(rst_n), .restart(state_d != state_q), .expired(phase_exp));

  assign we_fall = (state_d == ST_WPULSE) && (state_q != ST_WPULSE);

  eepw_gap_guard #(.LIMIT(GAP_LIMIT)) u_gap (
    .clk(clk), .rst_n(rst_n), .we_fall(we_fall), .stale(stale));

  eepw_poll_judge u_judge (
    .toggle_mode(mode_q), .rd_b7(rd_b7_q), .rd_b6(rd_b6_q),
    .saved_b7(data_q[DATA_W-1]), .prev_b6(prev_b6_q),
    .have_prev(have_prev_q), .complete(complete));

  assign last_read = (reads_q == RD_W'(POLL_READS_MAX));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (req_valid) state_d = ST_WAIT;
      ST_WAIT: begin
        if (s_valid) state_d = ST_WSETUP;
        else if (stale && cnt_q != '0) state_d = ST_PREL;
      end
      ST_WSETUP: if (phase_exp) state_d = ST_WPULSE;
      ST_WPULSE: if (phase_exp) state_d = ST_WHOLD;
      ST_WHOLD:  if (phase_exp) state_d = (cnt_q + 1'b1 == len_q) ? ST_PREL : ST_WAIT;
      ST_PREL:   state_d = ST_PREAD;
      ST_PREAD:  if (phase_exp) state_d = ST_PEND;
      ST_PEND:   if (phase_exp) state_d = (complete || last_read) ? ST_IDLE : ST_PREL;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      base_q      <= '0;
      addr_q      <= '0;
      len_q       <= '0;
      cnt_q       <= '0;
      data_q      <= '0;
      reads_q     <= '0;
      mode_q      <= 1'b0;
      short_q     <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      rd_b7_q     <= 1'b0;
      rd_b6_q     <= 1'b0;
      prev_b6_q   <= 1'b0;
      have_prev_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          base_q      <= req_addr;
          len_q       <= req_len;
          mode_q      <= req_toggle_mode;
          cnt_q       <= '0;
          short_q     <= 1'b0;
          have_prev_q <= 1'b0;
          reads_q     <= '0;
        end
        ST_WAIT: begin
          if (s_valid) begin
            data_q <= s_data;
            addr_q <= {base_q[ADDR_W-1:PAGE_BITS],
                       base_q[PAGE_BITS-1:0] + cnt_q[PAGE_BITS-1:0]};
          end else if (stale && cnt_q != '0) begin
            short_q <= 1'b1;
          end
        end
        ST_WHOLD: if (phase_exp) cnt_q <= cnt_q + 1'b1;
        ST_PREAD: if (phase_exp) begin
          rd_b7_q <= mem_dq_in[DATA_W-1];
          rd_b6_q <= mem_dq_in[DATA_W-2];
          reads_q <= reads_q + 1'b1;
        end
        ST_PEND: if (phase_exp) begin
          prev_b6_q   <= rd_b6_q;
          have_prev_q <= 1'b1;
          if (complete) done_q <= 1'b1;
          else if (last_read) err_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign s_ready     = (state_q == ST_WAIT);
  assign mem_we_n    = !(state_q == ST_WPULSE);
  assign mem_oe_n    = !(state_q == ST_PREAD);
  assign mem_ce_n    = !(state_q inside {ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_PREL, ST_PREAD});
  assign mem_dq_oe   = (state_q inside {ST_WSETUP, ST_WPULSE, ST_WHOLD});
  assign mem_addr    = addr_q;
  assign mem_dq_out  = data_q;
  assign done        = done_q;
  assign timeout_err = err_q;
  assign short_load  = short_q;
endmodule

// File: rtl/eepw_checker.sv
module eepw_checker #(
  parameter int ADDR_W    = 17,
  parameter int PAGE_BITS = 8,
  parameter int PHASE_CYC = 4,
  parameter int GAP_LIMIT = 10000
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      s_ready,
  input logic                      mem_ce_n,
  input logic                      mem_oe_n,
  input logic                      mem_we_n,
  input logic                      mem_dq_oe,
  input logic [ADDR_W-1:0]         mem_addr,
  input logic [ADDR_W-PAGE_BITS-1:0] page_q,
  input logic                      done,
  input logic                      timeout_err
);
  logic        we_prev_q, seen_q;
  int unsigned gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_prev_q <= 1'b1;
      seen_q    <= 1'b0;
      gap_q     <= 0;
    end else begin
      we_prev_q <= mem_we_n;
      if (req_valid && req_ready) begin
        seen_q <= 1'b0;
        gap_q  <= 0;
      end else if (we_prev_q && !mem_we_n) begin
        seen_q <= 1'b1;
        gap_q  <= 1;
      end else if (gap_q < 32'hFFFF_0000) begin
        gap_q <= gap_q + 1;
      end
    end
  end

  a_r3_write_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  a_r7_release_lead: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> $past(!mem_dq_oe));

  a_r10_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout_err));

  a_r4_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && s_ready));

  a_r2_page_lock: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_addr[ADDR_W-1:PAGE_BITS] == page_q));

  a_r5_we_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (we_prev_q && !mem_we_n && seen_q) |-> (gap_q <= GAP_LIMIT + PHASE_CYC + 1));
endmodule

bind eeprom_page_writer eepw_checker #(
  .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .PHASE_CYC(PHASE_CYC), .GAP_LIMIT(GAP_LIMIT)
) u_eepw_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .s_ready(s_ready), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr), .page_q(base_q[ADDR_W-1:PAGE_BITS]),
  .done(done), .timeout_err(timeout_err)
);

// File: tb/eeprom_page_writer_bench.sv
`timescale 1ns/1ps
module eeprom_page_writer_bench;
  localparam int AW = 17, DW = 8, PB = 8, PH = 2, GAP = 12, MAXR = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_toggle_mode = 1'b0, s_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [PB:0] req_len = '0;
  logic [DW-1:0] s_data = '0, mem_dq_in;
  logic req_ready, s_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic done, timeout_err, short_load;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;

  always #4 clk = ~clk;

  eeprom_page_writer #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(PB), .PHASE_CYC(PH),
                       .GAP_LIMIT(GAP), .POLL_READS_MAX(MAXR)) u_eeprom_page_writer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_toggle_mode(req_toggle_mode),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .done(done), .timeout_err(timeout_err), .short_load(short_load));

  int check_cnt = 0, fail_cnt = 0;
  logic [7:0] mem [256];
  logic [7:0] last_wr = '0, rd_val = '0;
  logic [AW-PB-1:0] exp_page = '0;
  int wr_count = 0, read_idx = 0, reads = 0, busy_n = 0;
  int page_bad = 0, bus_bad = 0, strobe_bad = 0, spacing_bad = 0;
  int since_fall = 0;
  bit seen_fall = 0;
  logic prev_we = 1'b1, prev_oe = 1'b1, prev_dqoe = 1'b0;

  assign mem_dq_in = rd_val;

  always @(posedge mem_we_n) if (rst_n && !mem_ce_n) begin
    mem[mem_addr[PB-1:0]] = mem_dq_out;
    last_wr  = mem_dq_out;
    wr_count = wr_count + 1;
    read_idx = 0;
    if (mem_addr[AW-1:PB] != exp_page) page_bad = page_bad + 1;
  end

  always @(negedge mem_oe_n) if (rst_n) begin
    if (read_idx < busy_n) rd_val = {~last_wr[7], read_idx[0], last_wr[5:0]};
    else rd_val = last_wr;
    read_idx = read_idx + 1;
    reads = reads + 1;
  end

  always @(negedge clk) if (rst_n) begin
    if (!mem_we_n && (mem_ce_n || !mem_oe_n)) strobe_bad++;
    if (!mem_oe_n && mem_dq_oe) bus_bad++;
    if (prev_oe && !mem_oe_n && prev_dqoe) bus_bad++;
    if (prev_we && !mem_we_n) begin
      if (seen_fall && since_fall > GAP + PH + 1) spacing_bad++;
      seen_fall = 1;
      since_fall = 1;
    end else since_fall++;
    prev_we = mem_we_n; prev_oe = mem_oe_n; prev_dqoe = mem_dq_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    check_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int j);
    return 8'((j * 37 + seed * 11 + 5) & 255);
  endfunction

  // Reads needed for completion, from the busy count and the last byte.
  function automatic int need_reads(input bit tog, input int busy, input logic [7:0] last);
    if (!tog) return busy + 1;
    for (int i = 1; i < busy + 3; i++) begin
      logic a, b;
      a = (i < busy) ? i[0] : last[6];
      b = ((i - 1) < busy) ? 1'(i - 1) : last[6];
      if (a == b) return i + 1;
    end
    return busy + 3;
  endfunction

  task automatic run(input int seed, input logic [AW-1:0] base, input int len, input int sent,
                     input bit tog, input int busy, input int stall_at, input int stall_len);
    int need, wait_cyc;
    bit got_done, got_err, got_short;
    logic [7:0] last;
    busy_n = busy; exp_page = base[AW-1:PB];
    wr_count = 0; reads = 0; page_bad = 0; bus_bad = 0; strobe_bad = 0; spacing_bad = 0;
    seen_fall = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    @(negedge clk);
    req_valid = 1; req_addr = base; req_len = (PB+1)'(len); req_toggle_mode = tog;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    s_valid = 1;
    for (int j = 0; j < sent; j++) begin
      if (j == stall_at) begin
        s_valid = 0;
        repeat (stall_len) @(negedge clk);
      end
      s_valid = 1; s_data = pat(seed, j);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 0;
    got_done = 0; got_err = 0; wait_cyc = 0;
    while (!done && !timeout_err && wait_cyc < 4000) begin
      @(negedge clk); wait_cyc++;
    end
    got_done = done; got_err = timeout_err; got_short = short_load;
    last = pat(seed, sent - 1);
    need = need_reads(tog, busy, last);
    if (need <= MAXR) begin
      chk(got_done && !got_err, tog ? "R9 done outcome" : "R8 done outcome", got_done, 1);
      chk(reads == need, tog ? "R9 read count" : "R8 read count", reads, need);
    end else begin
      chk(got_err && !got_done, "R10 timeout outcome", got_err, 1);
      chk(reads == MAXR, "R10 read count", reads, MAXR);
    end
    chk(wr_count == sent, "R4 bytes written", wr_count, sent);
    chk(got_short == (sent < len), "R6 short_load flag", got_short, sent < len);
    for (int j = 0; j < sent; j++) begin
      int a;
      a = (int'(base[PB-1:0]) + j) % 256;
      chk(mem[a] == pat(seed, j), "R2 byte content", mem[a], pat(seed, j));
    end
    chk(page_bad == 0, "R2 page bits", page_bad, 0);
    chk(strobe_bad == 0, "R3 write strobe", strobe_bad, 0);
    chk(bus_bad == 0, "R7 bus release", bus_bad, 0);
    chk(spacing_bad == 0, "R5 write spacing", spacing_bad, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", check_cnt - fail_cnt, check_cnt);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes idle", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dq_oe, "R1 bus released", mem_dq_oe, 0);
    chk(req_ready && !s_ready, "R1 ready state", {req_ready, s_ready}, 2);
    chk(!done && !timeout_err, "R1 no outcome", {done, timeout_err}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // Busy sweep in both modes; page wrap FE,FF,00 (R2); completion on the final read (R10)
    for (int tog = 0; tog < 2; tog++)
      for (int busy = 0; busy < 9; busy++)
        run(tog * 9 + busy, {9'h12A, 8'hFE}, 3, 3, 1'(tog), busy, -1, 0);
    run(40, {9'h055, 8'h10}, 1, 1, 1'b0, 2, -1, 0);
    run(41, {9'h0F0, 8'h40}, 256, 256, 1'b0, 2, -1, 0);
    run(42, {9'h0F1, 8'h00}, 256, 256, 1'b1, 3, -1, 0);
    // R6 stall inside the window: no short load
    run(43, {9'h003, 8'h20}, 4, 4, 1'b0, 1, 2, 10);
    // R6 stream stops after two of five bytes: short load
    run(44, {9'h004, 8'h80}, 5, 2, 1'b0, 1, -1, 0);
    run(45, {9'h005, 8'h81}, 5, 3, 1'b1, 2, -1, 0);
    $display("%0d/%0d checks passed", check_cnt - fail_cnt, check_cnt);
    $finish;
  end
endmodule